// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor Table

This block is a small fully associative table that the fetch stage of an in-order pipeline consults every cycle. It compares the current fetch address against the address tag of every valid entry. On a match it returns the address where fetch should continue. Each entry remembers four things: the address of a control-transfer instruction seen earlier, the target that instruction most recently went to, whether it is an unconditional jump, and a two-bit direction state. A matching jump always steers fetch to the stored target. A matching conditional branch steers fetch there only when its direction state leans taken.

The memory stage returns the resolved outcome through a single update port. The port carries the instruction address, a jump flag, the taken bit and the resolved target. An update for an address already in the table refreshes that entry in place. An update for a new address claims an entry only when the instruction actually went taken. The entry it takes is chosen by a rotating victim pointer, and the new entry starts in the weakly-taken state.

Each entry's direction state is a four-state machine: STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). It has two transitions per state: TAKEN_STEP moves one state toward STRONG_T and saturates there, and NOT_TAKEN_STEP moves one state toward STRONG_NT and saturates there. A third transition, ALLOC_LOAD, forces WEAK_T from any state when the entry is claimed. The whole lookup path is combinational from registered table contents, so an update written at a clock edge is first seen by the lookup in the cycle after it is presented.

Top module: `target_predict_cache`

## Requirements
- R1: After reset every entry is empty: `hit`, `pred_taken` and `pred_target` are all 0 for any `fetch_pc`.
- R2: `hit` is 1 exactly when `fetch_pc` equals the stored address of a valid entry. No two valid entries ever hold the same address. On a miss, `pred_taken` and `pred_target` are 0.
- R3: On a hit to an entry whose stored jump flag is 1, `pred_taken` is 1 whatever the direction state, and `pred_target` is the stored target.
- R4: On a hit to an entry whose jump flag is 0, `pred_taken` is 1 exactly when the direction state encoding is 2 (WEAK_T) or 3 (STRONG_T). `pred_target` shows the stored target on every hit.
- R5: A not-taken update (`upd_valid`=1, `upd_taken`=0) whose `upd_pc` matches no entry leaves the table unchanged. A later lookup of that address misses.
- R6: A taken update whose `upd_pc` matches no entry claims one entry. The entry gets tag `upd_pc`, target `upd_target`, jump flag `upd_is_jump` and direction state WEAK_T (2).
- R7: An update whose `upd_pc` matches an entry changes only that entry and claims no new one. The direction state takes TAKEN_STEP or NOT_TAKEN_STEP, and the jump flag is rewritten. The target is rewritten only when `upd_taken`=1.
- R8: Entries are claimed in round-robin order starting at index 0. With 8 entries, the ninth new address evicts the first address that was claimed.
- R9: A lookup and an update in the same cycle return the table contents from before the update. The update is visible from the next cycle.
- R10: The direction state saturates: a taken update in STRONG_T (3) stays at 3, and a not-taken update in STRONG_NT (0) stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| upd_valid | input | 1 | A resolved control transfer is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved instruction |
| upd_is_jump | input | 1 | Resolved instruction is an unconditional jump |
| upd_taken | input | 1 | Resolved direction was taken |
| upd_target | input | PC_W | Resolved target address |
| hit | output | 1 | `fetch_pc` matches a valid entry |
| pred_taken | output | 1 | Fetch should be redirected |
| pred_target | output | PC_W | Redirect address (stored target on a hit, else 0) |

## Verification
The bench drives one branch through every direction state, pushing it against both saturation limits. A counter that wraps would flip the prediction after the third taken or the second not-taken update. A jump is then driven with not-taken updates, because a design that let the counter gate jumps would drop the redirect. Not-taken reports for unknown addresses, same-cycle lookup of an address being written, and a ninth new address are all aimed at specific mistakes: a design that allocates on every update, forwards the update early, or picks victims in another order would hit, miss or keep the wrong entry. A long pseudo-random mix over twelve addresses is compared every cycle against a behavioural model to expose duplicate tags and lost refreshes.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

    // Two-bit direction state; encodings 2 and 3 predict taken.
    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'd0,
        DIR_WEAK_NT   = 2'd1,
        DIR_WEAK_T    = 2'd2,
        DIR_STRONG_T  = 2'd3
    } dir_state_t;

    localparam dir_state_t DIR_ON_ALLOC = DIR_WEAK_T;

endpackage

// File: rtl/tpc_dir_fsm.sv
`timescale 1ns/1ps
module tpc_dir_fsm
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_load,
    input  logic step_en,
    input  logic step_taken,
    output logic predict_taken
);

    dir_state_t state_q;
    dir_state_t state_d;

    // Next-state: ALLOC_LOAD, TAKEN_STEP, NOT_TAKEN_STEP
    always_comb begin
        state_d = state_q;
        if (alloc_load) begin
            state_d = DIR_ON_ALLOC;
        end else if (step_en) begin
            unique case (state_q)
                DIR_STRONG_NT: state_d = step_taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
                DIR_WEAK_NT:   state_d = step_taken ? DIR_WEAK_T   : DIR_STRONG_NT;
                DIR_WEAK_T:    state_d = step_taken ? DIR_STRONG_T : DIR_WEAK_NT;
                DIR_STRONG_T:  state_d = step_taken ? DIR_STRONG_T : DIR_WEAK_T;
                default:       state_d = DIR_ON_ALLOC;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIR_STRONG_NT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            DIR_STRONG_NT: predict_taken = 1'b0;
            DIR_WEAK_NT:   predict_taken = 1'b0;
            DIR_WEAK_T:    predict_taken = 1'b1;
            DIR_STRONG_T:  predict_taken = 1'b1;
            default:       predict_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/tpc_entry.sv
`timescale 1ns/1ps
module tpc_entry #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lookup_pc,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            alloc_en,
    input  logic            refresh_en,
    input  logic            upd_taken,
    input  logic            upd_is_jump,
    input  logic [PC_W-1:0] upd_target,
    output logic            lookup_match,
    output logic            upd_match,
    output logic            is_jump,
    output logic            dir_taken,
    output logic [PC_W-1:0] target
);

    logic            valid_q;
    logic [PC_W-1:0] tag_q;
    logic [PC_W-1:0] target_q;
    logic            jump_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            tag_q    <= '0;
            target_q <= '0;
            jump_q   <= 1'b0;
        end else if (alloc_en) begin
            valid_q  <= 1'b1;
            tag_q    <= upd_pc;
            target_q <= upd_target;
            jump_q   <= upd_is_jump;
        end else if (refresh_en) begin
            jump_q <= upd_is_jump;
            if (upd_taken) begin
                target_q <= upd_target;
            end
        end
    end

    tpc_dir_fsm u_dir (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_load    (alloc_en),
        .step_en       (refresh_en),
        .step_taken    (upd_taken),
        .predict_taken (dir_taken)
    );

    assign lookup_match = valid_q && (tag_q == lookup_pc);
    assign upd_match    = valid_q && (tag_q == upd_pc);
    assign is_jump      = jump_q;
    assign target       = target_q;

endmodule

// File: rtl/tpc_victim.sv
`timescale 1ns/1ps
module tpc_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    output logic [ENTRIES-1:0] victim_sel
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_sel
        assign victim_sel[g] = (ptr_q == IDX_W'(g));
    end

endmodule

// File: rtl/target_predict_cache.sv
`timescale 1ns/1ps
module target_predict_cache #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_is_jump,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    output logic            hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target
);

    logic [ENTRIES-1:0] lookup_vec;
    logic [ENTRIES-1:0] upd_vec;
    logic [ENTRIES-1:0] jump_vec;
    logic [ENTRIES-1:0] dir_vec;
    logic [ENTRIES-1:0] victim_sel;
    logic [PC_W-1:0]    tgt_arr [ENTRIES];

    logic upd_hit_any;
    logic do_alloc;
    logic sel_jump;
    logic sel_dir;
    logic [PC_W-1:0] sel_target;

    assign upd_hit_any = |upd_vec;
    assign do_alloc    = upd_valid && !upd_hit_any && upd_taken;

    tpc_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (do_alloc),
        .victim_sel (victim_sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        tpc_entry #(.PC_W(PC_W)) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .lookup_pc    (fetch_pc),
            .upd_pc       (upd_pc),
            .alloc_en     (do_alloc && victim_sel[g]),
            .refresh_en   (upd_valid && upd_vec[g]),
            .upd_taken    (upd_taken),
            .upd_is_jump  (upd_is_jump),
            .upd_target   (upd_target),
            .lookup_match (lookup_vec[g]),
            .upd_match    (upd_vec[g]),
            .is_jump      (jump_vec[g]),
            .dir_taken    (dir_vec[g]),
            .target       (tgt_arr[g])
        );
    end

    // Select the matching entry (tags are unique, lowest index wins anyway)
    always_comb begin
        sel_jump   = 1'b0;
        sel_dir    = 1'b0;
        sel_target = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lookup_vec[i]) begin
                sel_jump   = jump_vec[i];
                sel_dir    = dir_vec[i];
                sel_target = tgt_arr[i];
            end
        end
    end

    assign hit         = |lookup_vec;
    assign pred_taken  = hit && (sel_jump || sel_dir);
    assign pred_target = sel_target;

endmodule

// File: rtl/tpc_checker.sv
`timescale 1ns/1ps
module tpc_checker #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic               upd_is_jump,
    input logic               upd_taken,
    input logic [PC_W-1:0]    upd_target,
    input logic               hit,
    input logic               pred_taken,
    input logic [PC_W-1:0]    pred_target,
    input logic [ENTRIES-1:0] lookup_vec,
    input logic               upd_hit_any
);

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !hit);

    a_r2_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lookup_vec));

    a_r2_miss_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pred_target == '0));

    a_r4_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> hit);

    a_r3_jump_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_jump && upd_taken)
        |=> ((fetch_pc != $past(upd_pc)) || pred_taken));

    a_r5_no_alloc_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !upd_hit_any)
        |=> ((fetch_pc != $past(upd_pc)) || !hit));

    a_r9_update_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken)
        |=> ((fetch_pc != $past(upd_pc)) || (hit && (pred_target == $past(upd_target)))));

endmodule

bind target_predict_cache tpc_checker #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc    (fetch_pc),
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_is_jump (upd_is_jump),
    .upd_taken   (upd_taken),
    .upd_target  (upd_target),
    .hit         (hit),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .lookup_vec  (lookup_vec),
    .upd_hit_any (upd_hit_any)
);

// File: tb/tb_target_predict_cache.sv
`timescale 1ns/1ps
module tb_target_predict_cache;

    localparam int PC_W = 32;
    localparam int NENT = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_is_jump = 1'b0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;
    logic            hit;
    logic            pred_taken;
    logic [PC_W-1:0] pred_target;

    always #2.5 clk = ~clk;

    target_predict_cache #(.PC_W(PC_W), .ENTRIES(NENT)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_is_jump(upd_is_jump),
        .upd_taken(upd_taken), .upd_target(upd_target),
        .hit(hit), .pred_taken(pred_taken), .pred_target(pred_target)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Behavioural reference model
    bit              m_val [NENT];
    logic [PC_W-1:0] m_tag [NENT];
    logic [PC_W-1:0] m_tgt [NENT];
    bit              m_jmp [NENT];
    int              m_cnt [NENT];
    int              m_ptr;

    task automatic model_reset();
        for (int i = 0; i < NENT; i++) begin
            m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_jmp[i] = 0; m_cnt[i] = 0;
        end
        m_ptr = 0;
    endtask

    task automatic model_lookup(input logic [PC_W-1:0] pc, output bit h, output bit t,
                                output logic [PC_W-1:0] tg);
        h = 0; t = 0; tg = '0;
        for (int i = 0; i < NENT; i++) begin
            if (m_val[i] && m_tag[i] == pc) begin
                h = 1; tg = m_tgt[i]; t = m_jmp[i] || (m_cnt[i] >= 2);
            end
        end
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input bit j, input bit tk,
                                input logic [PC_W-1:0] tg);
        int idx = -1;
        for (int i = 0; i < NENT; i++) if (m_val[i] && m_tag[i] == pc) idx = i;
        if (idx >= 0) begin
            if (tk) begin
                if (m_cnt[idx] < 3) m_cnt[idx]++;
                m_tgt[idx] = tg;
            end else if (m_cnt[idx] > 0) begin
                m_cnt[idx]--;
            end
            m_jmp[idx] = j;
        end else if (tk) begin
            m_val[m_ptr] = 1; m_tag[m_ptr] = pc; m_tgt[m_ptr] = tg;
            m_jmp[m_ptr] = j; m_cnt[m_ptr] = 2;
            m_ptr = (m_ptr + 1) % NENT;
        end
    endtask

    task automatic compare(input string req, input bit eh, input bit et,
                           input logic [PC_W-1:0] etg);
        n_checks++;
        if (hit !== eh || pred_taken !== et || pred_target !== etg) begin
            n_fail++;
            $display("FAIL %s pc=%h: got hit=%0b taken=%0b tgt=%h, expected hit=%0b taken=%0b tgt=%h",
                     req, fetch_pc, hit, pred_taken, pred_target, eh, et, etg);
        end
    endtask

    // One cycle: drive, compare against model (pre-update contents), then apply update
    task automatic step(input logic [PC_W-1:0] fpc, input bit uv, input logic [PC_W-1:0] upc,
                        input bit uj, input bit ut, input logic [PC_W-1:0] utg, input string req);
        bit eh, et;
        logic [PC_W-1:0] etg;
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
        upd_is_jump = uj; upd_taken = ut; upd_target = utg;
        #1;
        model_lookup(fpc, eh, et, etg);
        compare(req, eh, et, etg);
        @(posedge clk);
        if (uv) model_update(upc, uj, ut, utg);
    endtask

    // Directed probe with explicit expected values derived from the requirements
    task automatic probe(input logic [PC_W-1:0] fpc, input bit eh, input bit et,
                         input logic [PC_W-1:0] etg, input string req);
        @(negedge clk);
        fetch_pc = fpc; upd_valid = 0;
        #1;
        compare(req, eh, et, etg);
        @(posedge clk);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input bit j, input bit tk,
                       input logic [PC_W-1:0] tg, input string req);
        step(32'h0000_0ff0, 1'b1, pc, j, tk, tg, req);
    endtask

    localparam logic [PC_W-1:0] PA = 32'h0000_0100;
    localparam logic [PC_W-1:0] PJ = 32'h0000_0300;
    localparam logic [PC_W-1:0] PB = 32'h0000_0400;

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty after reset
        probe(PA, 0, 0, '0, "R1");
        probe(32'h0, 0, 0, '0, "R1");

        // R9: same-cycle lookup sees old contents (miss), R6: allocate weakly taken
        step(PA, 1'b1, PA, 1'b0, 1'b1, 32'h200, "R9");
        probe(PA, 1, 1, 32'h200, "R6");

        // R4: one not-taken -> WEAK_NT, no redirect but target shown
        upd(PA, 0, 0, 32'h0, "R4");
        probe(PA, 1, 0, 32'h200, "R4");
        // R10: down to STRONG_NT and saturate
        upd(PA, 0, 0, 32'h0, "R10");
        upd(PA, 0, 0, 32'h0, "R10");
        upd(PA, 0, 1, 32'h200, "R10");
        probe(PA, 1, 0, 32'h200, "R10");   // state 1 after saturation at 0
        upd(PA, 0, 1, 32'h200, "R10");
        probe(PA, 1, 1, 32'h200, "R4");    // state 2
        upd(PA, 0, 1, 32'h200, "R10");
        upd(PA, 0, 1, 32'h200, "R10");     // saturates at 3
        upd(PA, 0, 0, 32'h0, "R10");
        probe(PA, 1, 1, 32'h200, "R10");   // state 2, still taken

        // R7: taken refresh rewrites target; not-taken keeps it
        upd(PA, 0, 1, 32'h240, "R7");
        probe(PA, 1, 1, 32'h240, "R7");
        upd(PA, 0, 0, 32'h999, "R7");
        probe(PA, 1, 1, 32'h240, "R7");

        // R3: jump predicted taken regardless of direction state
        upd(PJ, 1, 1, 32'h800, "R3");
        probe(PJ, 1, 1, 32'h800, "R3");
        upd(PJ, 1, 0, 32'h0, "R3");
        upd(PJ, 1, 0, 32'h0, "R3");
        upd(PJ, 1, 0, 32'h0, "R3");
        probe(PJ, 1, 1, 32'h800, "R3");

        // R5: not-taken report for unknown address claims nothing
        upd(PB, 0, 0, 32'h480, "R5");
        probe(PB, 0, 0, '0, "R5");

        // R8: six more fill entries 2..7, ninth address evicts PA (entry 0)
        for (int k = 0; k < 6; k++) upd(32'h500 + 32'(k * 16), 0, 1, 32'h900 + 32'(k), "R8");
        probe(PA, 1, 1, 32'h240, "R8");
        upd(32'h700, 0, 1, 32'hA00, "R8");
        probe(PA, 0, 0, '0, "R8");
        probe(PJ, 1, 1, 32'h800, "R8");
        probe(32'h700, 1, 1, 32'hA00, "R8");
        upd(32'h710, 0, 1, 32'hA10, "R8");
        probe(PJ, 0, 0, '0, "R8");

        // R2/R7/R9 mixed traffic against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 500; c++) begin
            logic [PC_W-1:0] fp, up;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fp = 32'h1000 + 32'(4 * (lfsr[3:0] % 12));
            up = 32'h1000 + 32'(4 * (lfsr[11:8] % 12));
            step(fp, lfsr[4], up, lfsr[5] & lfsr[6], lfsr[7] | lfsr[12],
                 32'h2000 + 32'(lfsr[15:8]), "R2");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule